// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

This block turns an interrupt event from a local source into exactly one 64-bit store request, which goes to an external interrupt controller. Each event carries a source number, a level-sensitive marker and a flag that says whether the source's two-bit state was already checked locally. The block combines these with its configuration inputs and produces a store address and store data. It then presents them on a valid/ready request channel and waits for the store response.

A configuration bit selects one of two encodings. In address-based mode, the store targets the controller's per-source management page. The page stride is 4 KiB or 64 KiB, chosen by a flag inside the port value, and the store data is zero. When the event was already checked, an inject offset is added so that the controller triggers without a condition. In indexed mode, every store goes to the port address, and the data carries the index base ORed with the source number. A trigger-state bit is added to the data when the event was already checked.

A second configuration bit moves the state check of message-signalled sources to the controller, so their checked flag is disregarded. Level-sensitive sources always count as checked. Only one trigger can be in flight at a time. A failed store raises a one-cycle error pulse and is not retried.

Top module: `trig_notify_gen`

## Requirements
- R1: After reset, st_valid is low, trig_ready is high and err_pulse is low.
- R2: With cfg_abt_mode=1 and port bit 0 clear (4 KiB page, shift 12), st_addr = (port with bit 0 cleared) | src<<13 | 1<<12, and st_data = 0.
- R3: With cfg_abt_mode=1 and port bit 0 set (64 KiB page, shift 16), st_addr = (port with bit 0 cleared) | src<<17 | 1<<16, and st_data = 0.
- R4: In address-based mode, an event that counts as checked also ORs the inject offset 0x800 into st_addr.
- R5: With cfg_abt_mode=0, st_addr equals cfg_port unchanged, and st_data = cfg_index | src.
- R6: In indexed mode, an event that counts as checked also sets bit 31 of st_data.
- R7: With cfg_msi_offload=1, a non-level source (trig_lsi=0) never counts as checked, whatever trig_checked is.
- R8: A level-sensitive source (trig_lsi=1) always counts as checked, whatever trig_checked and cfg_msi_offload are.
- R9: Address and data are captured when the trigger is accepted. They stay stable while st_valid is high and st_ready is low, even if the configuration changes.
- R10: trig_ready is low from acceptance until the store response arrives. A trigger offered in that window produces no second store.
- R11: A response with rsp_ok=0 gives err_pulse high for exactly one cycle and no retried store. A response with rsp_ok=1 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_abt_mode | input | 1 | 1 selects address-based mode, 0 selects indexed mode |
| cfg_msi_offload | input | 1 | 1 moves the state check of non-level sources to the controller |
| cfg_port | input | ADDR_W | Notification port value; bit 0 is the 64 KiB page flag |
| cfg_index | input | DATA_W | Index base used for indexed-mode data |
| trig_valid | input | 1 | Trigger offered |
| trig_ready | output | 1 | Trigger accepted when high together with trig_valid |
| trig_src | input | SRC_W | Source number |
| trig_lsi | input | 1 | Source is level-sensitive |
| trig_checked | input | 1 | Source state was checked locally |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request taken |
| st_addr | output | ADDR_W | Store address |
| st_data | output | DATA_W | Store data |
| rsp_valid | input | 1 | Store response valid |
| rsp_ok | input | 1 | Store response reports success |
| err_pulse | output | 1 | One-cycle pulse on a failed store |

## Verification
The bench uses the default parameters: 64-bit address and data, a 16-bit source number, and the page flag at bit 0. With these values, the highest source number 0xFFFF shifted for a 64 KiB page reaches address bit 32. This shows that the source field, page bit, inject offset and port base all sit in the right places without a wide search. The 16-bit source also leaves the indexed-mode trigger bit at position 31 clear of the source field, so a wrongly placed or missing trigger bit shows up in the data.

// File: rtl/trig_notify_pkg.sv
package trig_notify_pkg;
  typedef enum logic [1:0] {
    TN_IDLE = 2'd0,
    TN_REQ  = 2'd1,
    TN_RSP  = 2'd2
  } tn_state_e;
endpackage

// File: rtl/trig_notify_encode.sv
module trig_notify_encode #(
  parameter int unsigned ADDR_W        = 64,
  parameter int unsigned DATA_W        = 64,
  parameter int unsigned SRC_W         = 16,
  parameter int unsigned PAGE_FLAG_BIT = 0,
  parameter int unsigned SMALL_SHIFT   = 12,
  parameter int unsigned LARGE_SHIFT   = 16,
  parameter int unsigned INJECT_OFS    = 'h800,
  parameter int unsigned CHECKED_BIT   = 31
) (
  input  logic              abt_mode,
  input  logic              msi_offload,
  input  logic [ADDR_W-1:0] port,
  input  logic [DATA_W-1:0] index_base,
  input  logic [SRC_W-1:0]  src,
  input  logic              lsi,
  input  logic              checked,
  output logic [ADDR_W-1:0] enc_addr,
  output logic [DATA_W-1:0] enc_data
);
  localparam logic [ADDR_W-1:0] FLAG_MASK   = ADDR_W'(1) << PAGE_FLAG_BIT;
  localparam logic [ADDR_W-1:0] SMALL_PAGE  = ADDR_W'(1) << SMALL_SHIFT;
  localparam logic [ADDR_W-1:0] LARGE_PAGE  = ADDR_W'(1) << LARGE_SHIFT;
  localparam logic [ADDR_W-1:0] INJECT_MASK = ADDR_W'(INJECT_OFS);
  localparam logic [DATA_W-1:0] CHK_MASK    = DATA_W'(1) << CHECKED_BIT;

  logic              eff_checked;
  logic [ADDR_W-1:0] src_a;
  logic [ADDR_W-1:0] page_sel;
  logic [ADDR_W-1:0] abt_addr;
  logic [DATA_W-1:0] idx_data;

  // level sources are always checked; offload removes the local check for the rest
  assign eff_checked = lsi | (checked & ~msi_offload);
  assign src_a       = ADDR_W'(src);

  always_comb begin
    if (port[PAGE_FLAG_BIT])
      page_sel = (src_a << (LARGE_SHIFT + 1)) | LARGE_PAGE;
    else
      page_sel = (src_a << (SMALL_SHIFT + 1)) | SMALL_PAGE;
    abt_addr = (port & ~FLAG_MASK) | page_sel | (eff_checked ? INJECT_MASK : '0);
    idx_data = index_base | DATA_W'(src) | (eff_checked ? CHK_MASK : '0);
    if (abt_mode) begin
      enc_addr = abt_addr;
      enc_data = '0;
    end else begin
      enc_addr = port;
      enc_data = idx_data;
    end
  end
endmodule

// File: rtl/trig_notify_ctrl.sv
module trig_notify_ctrl
  import trig_notify_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [ADDR_W-1:0] enc_addr,
  input  logic [DATA_W-1:0] enc_data,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  output logic              err_pulse
);
  tn_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              cap_en;
  logic              err_q, err_d;

  assign trig_ready = (state_q == TN_IDLE);
  assign cap_en     = trig_ready & trig_valid;

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    unique case (state_q)
      TN_IDLE: if (trig_valid) state_d = TN_REQ;
      TN_REQ:  if (st_ready)   state_d = TN_RSP;
      TN_RSP:  if (rsp_valid) begin
                 state_d = TN_IDLE;
                 err_d   = ~rsp_ok;
               end
      default: state_d = TN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TN_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      addr_q <= enc_addr;
      data_q <= enc_data;
    end
  end

  assign st_valid  = (state_q == TN_REQ);
  assign st_addr   = addr_q;
  assign st_data   = data_q;
  assign err_pulse = err_q;

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_data)));
  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !trig_ready);
  a_r11_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pulse) |-> $past(rsp_valid && !rsp_ok));
  a_r11_no_retry: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !st_valid);
endmodule

// File: rtl/trig_notify_gen.sv
module trig_notify_gen #(
  parameter int unsigned ADDR_W        = 64,
  parameter int unsigned DATA_W        = 64,
  parameter int unsigned SRC_W         = 16,
  parameter int unsigned PAGE_FLAG_BIT = 0,
  parameter int unsigned INJECT_OFS    = 'h800,
  parameter int unsigned CHECKED_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_abt_mode,
  input  logic              cfg_msi_offload,
  input  logic [ADDR_W-1:0] cfg_port,
  input  logic [DATA_W-1:0] cfg_index,
  input  logic              trig_valid,
  output logic              trig_ready,
  input  logic [SRC_W-1:0]  trig_src,
  input  logic              trig_lsi,
  input  logic              trig_checked,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  input  logic              rsp_valid,
  input  logic              rsp_ok,
  output logic              err_pulse
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] enc_addr;
  logic [DATA_W-1:0] enc_data;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  trig_notify_encode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W),
    .PAGE_FLAG_BIT(PAGE_FLAG_BIT), .SMALL_SHIFT(12), .LARGE_SHIFT(16),
    .INJECT_OFS(INJECT_OFS), .CHECKED_BIT(CHECKED_BIT)
  ) u_enc (
    .abt_mode   (cfg_abt_mode),
    .msi_offload(cfg_msi_offload),
    .port       (cfg_port),
    .index_base (cfg_index),
    .src        (trig_src),
    .lsi        (trig_lsi),
    .checked    (trig_checked),
    .enc_addr   (enc_addr),
    .enc_data   (enc_data)
  );

  trig_notify_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .trig_valid(trig_valid),
    .trig_ready(trig_ready),
    .enc_addr  (enc_addr),
    .enc_data  (enc_data),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .err_pulse (err_pulse)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (trig_ready && !st_valid && !err_pulse));
endmodule

// File: tb/tb_trig_notify_gen.sv
module tb_trig_notify_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_abt_mode, cfg_msi_offload;
  logic [63:0] cfg_port, cfg_index;
  logic        trig_valid, trig_ready;
  logic [15:0] trig_src;
  logic        trig_lsi, trig_checked;
  logic        st_valid, st_ready;
  logic [63:0] st_addr, st_data;
  logic        rsp_valid, rsp_ok, err_pulse;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  trig_notify_gen dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_abt(input logic [63:0] port, input logic [15:0] src,
                                          input logic c);
    int sh = port[0] ? 16 : 12;
    return (port & ~64'h1) | (64'(src) << (sh + 1)) | (64'h1 << sh) | (c ? 64'h800 : 64'h0);
  endfunction

  function automatic logic [63:0] exp_idx(input logic [63:0] idx, input logic [15:0] src,
                                          input logic c);
    return idx | 64'(src) | (c ? 64'h8000_0000 : 64'h0);
  endfunction

  // offer one trigger, check the store, finish it with the given response
  task automatic one_trigger(input string req, input logic [15:0] src, input logic lsi,
                             input logic c, input logic [63:0] ea, input logic [63:0] ed,
                             input logic ok);
    @(negedge clk);
    trig_src = src; trig_lsi = lsi; trig_checked = c; trig_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
    chk({req, " st_valid"}, 64'(st_valid), 64'h1);
    chk({req, " addr"}, st_addr, ea);
    chk({req, " data"}, st_data, ed);
    st_ready = 1'b1;
    @(negedge clk);
    st_ready = 1'b0; rsp_valid = 1'b1; rsp_ok = ok;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk({req, " err"}, 64'(err_pulse), 64'(!ok));
    chk({req, " ready back"}, 64'(trig_ready), 64'h1);
  endtask

  task automatic t_reset;
    chk("R1 st_valid", 64'(st_valid), 64'h0);
    chk("R1 trig_ready", 64'(trig_ready), 64'h1);
    chk("R1 err", 64'(err_pulse), 64'h0);
  endtask

  task automatic t_abt;
    cfg_abt_mode = 1'b1; cfg_msi_offload = 1'b0;
    cfg_port = 64'h0000_0060_0000_0000;
    one_trigger("R2 4K", 16'h0005, 1'b0, 1'b0, exp_abt(cfg_port, 16'h0005, 1'b0), 64'h0, 1'b1);
    cfg_port = 64'h0000_0060_0000_0001;
    one_trigger("R3 64K", 16'hFFFF, 1'b0, 1'b0, exp_abt(cfg_port, 16'hFFFF, 1'b0), 64'h0, 1'b1);
    one_trigger("R4 inject", 16'h0003, 1'b0, 1'b1, exp_abt(cfg_port, 16'h0003, 1'b1), 64'h0, 1'b1);
    cfg_port = 64'h0000_0060_0000_0000;
    one_trigger("R4 inject 4K", 16'h0001, 1'b0, 1'b1, 64'h0000_0060_0000_3800, 64'h0, 1'b1);
  endtask

  task automatic t_idx;
    cfg_abt_mode = 1'b0; cfg_msi_offload = 1'b0;
    cfg_port = 64'h0000_0060_0000_1001;
    cfg_index = 64'h0000_0000_0012_0000;
    one_trigger("R5 indexed", 16'h00AB, 1'b0, 1'b0, cfg_port, exp_idx(cfg_index, 16'h00AB, 1'b0), 1'b1);
    one_trigger("R6 indexed chk", 16'h00AB, 1'b0, 1'b1, cfg_port, exp_idx(cfg_index, 16'h00AB, 1'b1), 1'b1);
  endtask

  task automatic t_offload;
    cfg_msi_offload = 1'b1;
    one_trigger("R7 idx msi", 16'h0010, 1'b0, 1'b1, cfg_port, exp_idx(cfg_index, 16'h0010, 1'b0), 1'b1);
    one_trigger("R8 idx lsi", 16'h0011, 1'b1, 1'b0, cfg_port, exp_idx(cfg_index, 16'h0011, 1'b1), 1'b1);
    cfg_abt_mode = 1'b1; cfg_port = 64'h0000_0070_0000_0000;
    one_trigger("R7 abt msi", 16'h0022, 1'b0, 1'b1, exp_abt(cfg_port, 16'h0022, 1'b0), 64'h0, 1'b1);
    one_trigger("R8 abt lsi", 16'h0023, 1'b1, 1'b0, exp_abt(cfg_port, 16'h0023, 1'b1), 64'h0, 1'b1);
    cfg_msi_offload = 1'b0;
    one_trigger("R8 lsi no offload", 16'h0024, 1'b1, 1'b0, exp_abt(cfg_port, 16'h0024, 1'b1), 64'h0, 1'b1);
  endtask

  task automatic t_hold_busy;
    logic [63:0] ea;
    cfg_abt_mode = 1'b1; cfg_msi_offload = 1'b0; cfg_port = 64'h0000_0080_0000_0000;
    ea = exp_abt(cfg_port, 16'h0042, 1'b0);
    @(negedge clk);
    trig_src = 16'h0042; trig_lsi = 1'b0; trig_checked = 1'b0; trig_valid = 1'b1;
    @(negedge clk);
    trig_src = 16'h0099;           // keeps offering while busy
    cfg_port = 64'h0000_0090_0000_0001;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 addr held", st_addr, ea);
      chk("R9 data held", st_data, 64'h0);
      chk("R10 not ready", 64'(trig_ready), 64'h0);
    end
    st_ready = 1'b1;
    @(negedge clk);
    st_ready = 1'b0;
    chk("R10 not ready rsp wait", 64'(trig_ready), 64'h0);
    chk("R10 no second store", 64'(st_valid), 64'h0);
    rsp_valid = 1'b1; rsp_ok = 1'b1; trig_valid = 1'b0;
    @(negedge clk);
    rsp_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 no extra store", 64'(st_valid), 64'h0);
    end
  endtask

  task automatic t_error;
    cfg_abt_mode = 1'b0; cfg_port = 64'h0000_0060_0000_2000; cfg_index = 64'h0;
    one_trigger("R11 bad rsp", 16'h0007, 1'b0, 1'b0, cfg_port, 64'h7, 1'b0);
    @(negedge clk);
    chk("R11 pulse ends", 64'(err_pulse), 64'h0);
    chk("R11 no retry", 64'(st_valid), 64'h0);
    @(negedge clk);
    chk("R11 no retry later", 64'(st_valid), 64'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_abt_mode = 1'b0; cfg_msi_offload = 1'b0; cfg_port = '0; cfg_index = '0;
    trig_valid = 1'b0; trig_src = '0; trig_lsi = 1'b0; trig_checked = 1'b0;
    st_ready = 1'b0; rsp_valid = 1'b0; rsp_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_abt();
    t_idx();
    t_offload();
    t_hold_busy();
    t_error();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule